// File: doc/BRIEF.md
# Packed-Byte SIMD Arithmetic/Logic Unit

This block is a purely combinational 16-bit arithmetic/logic unit. A 4-bit function select picks one of twelve operations on two 16-bit operands, `opnd_a` and `opnd_b`, and the 16-bit `result` follows the inputs with no clock and no storage. Besides the usual bitwise, add, subtract, compare and shift operations, it treats each operand as two packed 8-bit lanes. Lane-parallel forms combine matching bytes of the two operands. Horizontal forms combine the two bytes inside one operand.

A datapath uses it for register-register operations and for immediate operations alike. The decoder places the widened immediate on `opnd_b` and drives the matching function select. The unit produces no flags, no carry-out and no overflow indication.

The house style calls for a state machine, which this block does not have. The only named encoding is the function select of R1 to R12. The top selects exactly one of four sub-units (bitwise, lane, shift, full-width arithmetic), or the constant zero.

Top module: `simd_byte_alu`

## Requirements
- R1: Select 0 gives the bitwise OR of `opnd_a` and `opnd_b`. Select 1 gives their bitwise AND.
- R2: Select 2 (lane add) gives high byte = A[15:8]+B[15:8] and low byte = A[7:0]+B[7:0]. Each byte wraps modulo 256, and no carry passes from the low lane into the high lane.
- R3: Select 3 (lane subtract) gives high byte = A[15:8]-B[15:8] and low byte = A[7:0]-B[7:0]. Each byte wraps modulo 256 on its own, and no borrow crosses lanes.
- R4: Select 4 (horizontal add) gives high byte = A[15:8]+A[7:0] and low byte = B[15:8]+B[7:0], each modulo 256.
- R5: Select 5 (horizontal subtract) gives high byte = A[15:8]-A[7:0] and low byte = B[15:8]-B[7:0], each modulo 256.
- R6: Select 6 shifts A left by B[3:0] places and fills with zeros. B[15:4] has no effect on any shift.
- R7: Select 7 shifts A right by B[3:0] places and fills with zeros.
- R8: Select 8 shifts A right by B[3:0] places and fills with copies of A[15].
- R9: Select 9 gives A+B modulo 2^16.
- R10: Select 10 gives A-B modulo 2^16.
- R11: Select 11 gives 16'h0001 when A is less than B as signed two's complement numbers, and 16'h0000 otherwise, including when A equals B.
- R12: Selects 12 to 15 give 16'h0000 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand; its bits 3:0 give the shift amount |
| func_sel | input | 4 | Operation select, codes 0 to 15 |
| result | output | 16 | Combinational result |

## Verification
Immediate assertions watch every input change. They check that lane add undoes into its operands in each byte, and that full-width add and subtract invert into their operands. They check the fill bit of each shift direction, that the compare result is 0 or 1, and that unused selects read zero. Only the bench shows exact values. This covers carries held back at the lane boundary, horizontal sums, the shift amount taken from B[3:0] alone, signed ordering across the sign boundary, and the twelve operations under random operands.

// File: rtl/sba_pkg.sv
`timescale 1ns/1ps
package sba_pkg;

    typedef enum logic [3:0] {
        FN_OR    = 4'd0,
        FN_AND   = 4'd1,
        FN_LADD  = 4'd2,
        FN_LSUB  = 4'd3,
        FN_HADD  = 4'd4,
        FN_HSUB  = 4'd5,
        FN_SHL   = 4'd6,
        FN_SHRL  = 4'd7,
        FN_SHRA  = 4'd8,
        FN_ADD   = 4'd9,
        FN_SUB   = 4'd10,
        FN_SLT   = 4'd11
    } func_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shmode_e;

endpackage

// File: rtl/sba_lane_unit.sv
`timescale 1ns/1ps
module sba_lane_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             horiz,
    input  logic             sub,
    output logic [WIDTH-1:0] res
);
    localparam int LW     = WIDTH / 2;
    localparam int NLANES = 2;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LW-1:0] x;
        logic [LW-1:0] y;
        // Horizontal: high lane folds A, low lane folds B.
        if (g == NLANES - 1) begin : g_hi
            assign x = horiz ? a[WIDTH-1:LW] : a[g*LW +: LW];
            assign y = horiz ? a[LW-1:0]     : b[g*LW +: LW];
        end else begin : g_lo
            assign x = horiz ? b[WIDTH-1:LW] : a[g*LW +: LW];
            assign y = horiz ? b[LW-1:0]     : b[g*LW +: LW];
        end
        assign res[g*LW +: LW] = sub ? (x - y) : (x + y);
    end

endmodule

// File: rtl/sba_shift_unit.sv
`timescale 1ns/1ps
module sba_shift_unit
    import sba_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         a,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  shmode_e                  mode,
    output logic [WIDTH-1:0]         res
);
    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] a_rev;
    logic [WIDTH-1:0] out_rev;
    logic [WIDTH-1:0] stg [0:SHW];
    logic             fill;
    logic             left;

    assign left = (mode == SH_LEFT);
    assign fill = (mode == SH_RARI) & a[WIDTH-1];

    // Left shifts reuse the right-shift barrel on a bit-reversed word.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign a_rev[i]   = a[WIDTH-1-i];
        assign out_rev[i] = stg[SHW][WIDTH-1-i];
    end

    assign stg[0] = left ? a_rev : a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][WIDTH-1:D]} : stg[s];
    end

    assign res = left ? out_rev : stg[SHW];

    always_comb begin
        if (!$isunknown({a, amt, mode})) begin
            // R6: a left shift by a nonzero amount clears bit 0
            a_r6_shl_zero_fill: assert (!(left && amt != '0) || res[0] == 1'b0)
                else $error("a_r6_shl_zero_fill");
            // R7: a logical right shift by a nonzero amount clears the top bit
            a_r7_shrl_zero_fill: assert (!(mode == SH_RLOG && amt != '0) || res[WIDTH-1] == 1'b0)
                else $error("a_r7_shrl_zero_fill");
            // R8: an arithmetic right shift keeps the sign bit
            a_r8_shra_sign_fill: assert (mode != SH_RARI || res[WIDTH-1] == a[WIDTH-1])
                else $error("a_r8_shra_sign_fill");
        end
    end

endmodule

// File: rtl/sba_arith_unit.sv
`timescale 1ns/1ps
module sba_arith_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic [WIDTH-1:0] lt
);
    logic sgn_lt;

    assign sum    = a + b;
    assign diff   = a - b;
    assign sgn_lt = $signed(a) < $signed(b);
    assign lt     = {{(WIDTH-1){1'b0}}, sgn_lt};

    always_comb begin
        if (!$isunknown({a, b})) begin
            // R9: the sum minus B gives A back
            a_r9_add_inverse: assert ((sum - b) == a)
                else $error("a_r9_add_inverse");
            // R10: the difference plus B gives A back
            a_r10_sub_inverse: assert ((diff + b) == a)
                else $error("a_r10_sub_inverse");
            // R11: a value is never less than itself
            a_r11_slt_irreflexive: assert (a != b || lt == '0)
                else $error("a_r11_slt_irreflexive");
        end
    end

endmodule

// File: rtl/simd_byte_alu.sv
`timescale 1ns/1ps
module simd_byte_alu
    import sba_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int FUNC_W = 4
) (
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [FUNC_W-1:0] func_sel,
    output logic [WIDTH-1:0]  result
);
    localparam int LW  = WIDTH / 2;
    localparam int SHW = $clog2(WIDTH);

    func_e            fn;
    logic             lane_horiz;
    logic             lane_sub;
    shmode_e          sh_mode;
    logic [WIDTH-1:0] lane_res;
    logic [WIDTH-1:0] sh_res;
    logic [WIDTH-1:0] ar_sum;
    logic [WIDTH-1:0] ar_diff;
    logic [WIDTH-1:0] ar_lt;

    assign fn = func_e'(func_sel);

    // Decode the controls that steer the shared sub-units.
    always_comb begin
        lane_horiz = (fn == FN_HADD) || (fn == FN_HSUB);
        lane_sub   = (fn == FN_LSUB) || (fn == FN_HSUB);
        unique case (fn)
            FN_SHRL: sh_mode = SH_RLOG;
            FN_SHRA: sh_mode = SH_RARI;
            default: sh_mode = SH_LEFT;
        endcase
    end

    sba_lane_unit #(.WIDTH(WIDTH)) u_lane (
        .a     (opnd_a),
        .b     (opnd_b),
        .horiz (lane_horiz),
        .sub   (lane_sub),
        .res   (lane_res)
    );

    sba_shift_unit #(.WIDTH(WIDTH)) u_shift (
        .a    (opnd_a),
        .amt  (opnd_b[SHW-1:0]),
        .mode (sh_mode),
        .res  (sh_res)
    );

    sba_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a    (opnd_a),
        .b    (opnd_b),
        .sum  (ar_sum),
        .diff (ar_diff),
        .lt   (ar_lt)
    );

    // Result select; unused codes fall through to zero.
    always_comb begin
        case (fn)
            FN_OR:                           result = opnd_a | opnd_b;
            FN_AND:                          result = opnd_a & opnd_b;
            FN_LADD, FN_LSUB,
            FN_HADD, FN_HSUB:                result = lane_res;
            FN_SHL, FN_SHRL, FN_SHRA:        result = sh_res;
            FN_ADD:                          result = ar_sum;
            FN_SUB:                          result = ar_diff;
            FN_SLT:                          result = ar_lt;
            default:                         result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, func_sel})) begin
            // R12: unused codes read zero
            a_r12_unused_zero: assert (func_sel < 4'd12 || result == '0)
                else $error("a_r12_unused_zero");
            // R11: the compare yields only 0 or 1
            a_r11_slt_boolean: assert (fn != FN_SLT || result[WIDTH-1:1] == '0)
                else $error("a_r11_slt_boolean");
            // R2: each lane sum, less the B byte, gives back the A byte
            a_r2_lane_add_isolated: assert (fn != FN_LADD ||
                ((result[WIDTH-1:LW] - opnd_b[WIDTH-1:LW]) == opnd_a[WIDTH-1:LW] &&
                 (result[LW-1:0] - opnd_b[LW-1:0]) == opnd_a[LW-1:0]))
                else $error("a_r2_lane_add_isolated");
            // R1: an OR result covers both operands
            a_r1_or_covers: assert (fn != FN_OR || (result & (opnd_a | opnd_b)) == (opnd_a | opnd_b))
                else $error("a_r1_or_covers");
        end
    end

endmodule

// File: tb/simd_byte_alu_test.sv
`timescale 1ns/1ps
module simd_byte_alu_test;

    logic        clk = 1'b0;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic [3:0]  func_sel;
    logic [15:0] result;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    simd_byte_alu uut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .func_sel (func_sel),
        .result   (result)
    );

    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'd0, 4'd1: return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [3:0] f);
        logic [7:0] ah, al, bh, bl;
        logic [3:0] n;
        logic [15:0] r;
        ah = a[15:8]; al = a[7:0]; bh = b[15:8]; bl = b[7:0];
        n  = b[3:0];
        case (f)
            4'd0:  r = a | b;
            4'd1:  r = a & b;
            4'd2:  begin r[15:8] = ah + bh; r[7:0] = al + bl; end
            4'd3:  begin r[15:8] = ah - bh; r[7:0] = al - bl; end
            4'd4:  begin r[15:8] = ah + al; r[7:0] = bh + bl; end
            4'd5:  begin r[15:8] = ah - al; r[7:0] = bh - bl; end
            4'd6:  begin r = a; for (int k = 0; k < 16; k++) if (k < int'(n)) r = {r[14:0], 1'b0}; end
            4'd7:  begin r = a; for (int k = 0; k < 16; k++) if (k < int'(n)) r = {1'b0, r[15:1]}; end
            4'd8:  begin r = a; for (int k = 0; k < 16; k++) if (k < int'(n)) r = {a[15], r[15:1]}; end
            4'd9:  r = a + b;
            4'd10: r = a - b;
            4'd11: begin
                if (a[15] != b[15]) r = {15'd0, a[15]};
                else                r = {15'd0, a < b};
            end
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [3:0] f,
                       input logic [15:0] exp, input string tag);
        @(negedge clk);
        opnd_a = a; opnd_b = b; func_sel = f;
        #2;
        total++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d a=%h b=%h got=%h exp=%h", tag, f, a, b, result, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        opnd_a = 16'h0; opnd_b = 16'h0; func_sel = 4'd0;
        // reset state: zero operands on OR give zero
        run(16'h0000, 16'h0000, 4'd0, 16'h0000, "R1 idle");
        run(16'hF0F0, 16'h0F01, 4'd0, 16'hFFF1, "R1 or");
        run(16'hF0F0, 16'h3C3C, 4'd1, 16'h3030, "R1 and");
        run(16'h00FF, 16'h0001, 4'd2, 16'h0000, "R2 no carry into high lane");
        run(16'hFF80, 16'h0180, 4'd2, 16'h0000, "R2 both lanes wrap");
        run(16'h0000, 16'h0101, 4'd3, 16'hFFFF, "R3 no borrow across lanes");
        run(16'h1005, 16'h0107, 4'd3, 16'h0FFE, "R3 low lane wraps alone");
        run(16'h8080, 16'h01FF, 4'd4, 16'h0000, "R4 horizontal wrap");
        run(16'h1234, 16'h0506, 4'd4, 16'h460B, "R4 horizontal add");
        run(16'h0102, 16'h0900, 4'd5, 16'hFF09, "R5 horizontal sub");
        run(16'h0001, 16'hFFF3, 4'd6, 16'h0008, "R6 upper B bits ignored");
        run(16'hFFFF, 16'h000F, 4'd6, 16'h8000, "R6 max shift");
        run(16'h8000, 16'h000F, 4'd7, 16'h0001, "R7 zero fill");
        run(16'h8000, 16'h00F0, 4'd7, 16'h8000, "R7 amount zero");
        run(16'h8000, 16'h000F, 4'd8, 16'hFFFF, "R8 sign fill");
        run(16'h4000, 16'h0002, 4'd8, 16'h1000, "R8 positive");
        run(16'hFFFF, 16'h0001, 4'd9, 16'h0000, "R9 wrap");
        run(16'h0000, 16'h0001, 4'd10, 16'hFFFF, "R10 wrap");
        run(16'h8000, 16'h0001, 4'd11, 16'h0001, "R11 negative below positive");
        run(16'h0001, 16'h8000, 4'd11, 16'h0000, "R11 positive not below negative");
        run(16'h7FFF, 16'h7FFF, 4'd11, 16'h0000, "R11 equal");
        run(16'hFFFE, 16'hFFFF, 4'd11, 16'h0001, "R11 both negative");
        for (int c = 12; c < 16; c++)
            run(16'hFFFF, 16'hFFFF, 4'(c), 16'h0000, "R12 unused code");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 2400; i++) begin
            logic [15:0] ra, rb;
            logic [3:0]  rf;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rf = 4'($urandom);
            if (i % 8 == 0) ra[7:0] = 8'hFF;
            if (i % 11 == 0) rb = {rb[15:8], 8'h01};
            run(ra, rb, rf, model(ra, rb, rf), req_of(rf));
        end
        finish_run();
    end

endmodule